// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block is a synthesizable stand-in for a small serial EEPROM of 16-bit words. A master reaches it through four pins: a select, a serial clock, a serial data input and a serial data output. The serial pins are sampled in the system clock domain. A rising serial clock edge is found by a synchronizer and an edge detector. A command decoder then shifts in a start bit, a two-bit opcode, an address of `ADDR_W` bits and, where the command needs one, a 16-bit data word. Every field is sent most significant bit first.

A programming command changes the word array in the cycle after its final bit is taken. It also starts a busy timer of `BUSY_CYCLES` system clocks. The master ends the command by dropping select. When it raises select again, the data output reports status: low while the timer runs, high once it has expired. A write-enable latch stays clear after reset and after a disable command. While it is clear, every programming command is discarded.

The model is meant for chip-level simulation and for emulation. In those settings a controller that polls a real part needs a target with the same cycle behaviour.

Top module: `mw_eeprom_model`

## Requirements
- R1: After reset the data output is low, the write-enable latch is clear, and every word reads back as 0xFFFF.
- R2: A read is a 1 start bit, opcode bits 1,0 and the address. The last address edge drives a 0 on the data output. Each of the next 16 rising serial clock edges then drives one bit of the word, bit 15 first.
- R3: A write is a start bit, opcode bits 0,1, the address and then 16 data bits, bit 15 first. When writes are enabled, it stores the word at that address.
- R4: An erase is a start bit, opcode bits 1,1 and the address. When writes are enabled, it sets that one word to 0xFFFF and leaves the other words unchanged.
- R5: Opcode bits 0,0 select an extended command through the two top address bits; the lower address bits are ignored. Top bits 1,1 set the write-enable latch, and top bits 0,0 clear it.
- R6: An extended command with top address bits 1,0 sets every word to 0xFFFF when writes are enabled.
- R7: An extended command with top address bits 0,1 is followed by 16 data bits. When writes are enabled, it stores that value in every word.
- R8: While the write-enable latch is clear, no programming command changes any word or starts the busy status.
- R9: After an accepted programming command, select is dropped and raised again. The data output is then low until `BUSY_CYCLES` system clocks have passed since the command was accepted, and high after that.
- R10: Dropping select before a command is complete discards it. The addressed word keeps its value, and the next command is decoded normally.
- R11: While programming is in progress a start bit is not accepted. The data output keeps reporting status, and it goes high when the busy period ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| cs | input | 1 | Select from the master; high frames a command |
| sclk | input | 1 | Serial clock from the master; data is taken on its rising edge |
| sdi | input | 1 | Serial command, address and data bits from the master |
| sdo | output | 1 | Serial read data, or ready/busy status after a programming command |

## Verification
The bench works on a 64-word configuration. It writes every address with a value computed arithmetically from the address, then reads all of them back. A swapped bit order, a lost dummy bit or an address decode error therefore shows up as a mismatch on some specific word. A second pair of sweeps runs after the fill command and after the clear-all command. These tell a single-word update apart from an array-wide one, and an erase apart from a fill. Further runs separate a locked latch from an unlocked one and a completed command from one cut short by select. The last case is a start bit sent while busy, which must leave the status on the output.

// File: rtl/mw_pkg.sv
package mw_pkg;

  // decoder phases
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_SINK
  } mw_state_e;

  // two-bit opcode following the start bit
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;

  // extended function carried in the two top address bits
  typedef enum logic [1:0] {
    EX_LOCK   = 2'b00,
    EX_FILL   = 2'b01,
    EX_CLEAR  = 2'b10,
    EX_UNLOCK = 2'b11
  } mw_ext_e;

endpackage

// File: rtl/mw_edge_sync.sv
module mw_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_pin,
  input  logic sclk_pin,
  input  logic sdi_pin,
  output logic cs_s,
  output logic sdi_s,
  output logic rise
);

  localparam int NPIN = 3;

  logic [NPIN-1:0] meta_q, sync_q;
  logic            sclk_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_q   <= '0;
      sclk_d_q <= 1'b0;
    end else begin
      meta_q   <= {cs_pin, sclk_pin, sdi_pin};
      sync_q   <= meta_q;
      sclk_d_q <= sync_q[1];
    end
  end

  assign cs_s  = sync_q[2];
  assign sdi_s = sync_q[0];
  assign rise  = sync_q[1] & ~sclk_d_q;

  // a detected edge lasts one system clock
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);

  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [BW-1:0] LOAD = BW'(BUSY_CYCLES);

  logic [BW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (launch)
      cnt_n = LOAD;
    else if (cnt_q != '0)
      cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);

  // R11
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);

  // R9
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_one,
  input  logic              wr_all,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = wr_all | (wr_one & (wr_addr == ADDR_W'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   words[g] <= '1;
      else if (hit) words[g] <= wr_data;
    end
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/mw_cmd_decoder.sv
module mw_cmd_decoder
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sdi_s,
  input  logic              rise,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_one,
  output logic              wr_all,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              launch,
  output logic              sdo
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] READ_END  = CNT_W'(DATA_W);

  mw_state_e         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  mw_op_e            opc_q, opc_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic [DATA_W-1:0] rd_q, rd_n;
  logic              we_q, we_n;
  logic              stat_q, stat_n;
  logic              sdo_q, sdo_n;
  logic [ADDR_W-1:0] addr_full;

  assign addr_full = {addr_q[ADDR_W-2:0], sdi_s};
  assign rd_addr   = addr_full;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    opc_n   = opc_q;
    addr_n  = addr_q;
    data_n  = data_q;
    rd_n    = rd_q;
    we_n    = we_q;
    stat_n  = stat_q;
    sdo_n   = sdo_q;
    wr_one  = 1'b0;
    wr_all  = 1'b0;
    wr_addr = addr_q;
    wr_data = data_q;
    launch  = 1'b0;

    if (!cs_s) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      sdo_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          sdo_n = stat_q & ~busy;
          if (rise && sdi_s && !busy) begin
            st_n   = ST_OPC;
            cnt_n  = '0;
            stat_n = 1'b0;
            sdo_n  = 1'b0;
          end
        end

        ST_OPC: begin
          if (rise) begin
            opc_n = mw_op_e'({opc_q[0], sdi_s});
            if (cnt_q != '0) begin
              st_n  = ST_ADDR;
              cnt_n = '0;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end

        ST_ADDR: begin
          if (rise) begin
            addr_n = addr_full;
            if (cnt_q == ADDR_LAST) begin
              cnt_n = '0;
              st_n  = ST_SINK;
              unique case (opc_q)
                OP_READ: begin
                  rd_n  = rd_word;
                  st_n  = ST_READ;
                  sdo_n = 1'b0;
                end
                OP_WRITE: st_n = ST_DATA;
                OP_ERASE: begin
                  if (we_q) begin
                    wr_one  = 1'b1;
                    wr_addr = addr_full;
                    wr_data = '1;
                    launch  = 1'b1;
                    stat_n  = 1'b1;
                  end
                end
                OP_EXT: begin
                  unique case (mw_ext_e'(addr_full[ADDR_W-1 -: 2]))
                    EX_UNLOCK: we_n = 1'b1;
                    EX_LOCK:   we_n = 1'b0;
                    EX_FILL:   st_n = ST_DATA;
                    EX_CLEAR: begin
                      if (we_q) begin
                        wr_all  = 1'b1;
                        wr_data = '1;
                        launch  = 1'b1;
                        stat_n  = 1'b1;
                      end
                    end
                  endcase
                end
              endcase
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end

        ST_DATA: begin
          if (rise) begin
            data_n = {data_q[DATA_W-2:0], sdi_s};
            if (cnt_q == DATA_LAST) begin
              cnt_n = '0;
              st_n  = ST_SINK;
              if (we_q) begin
                wr_one  = (opc_q == OP_WRITE);
                wr_all  = (opc_q == OP_EXT);
                wr_data = data_n;
                launch  = 1'b1;
                stat_n  = 1'b1;
              end
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end

        ST_READ: begin
          if (rise) begin
            if (cnt_q == READ_END) begin
              st_n  = ST_SINK;
              sdo_n = 1'b0;
            end else begin
              sdo_n = rd_q[DATA_W-1];
              rd_n  = {rd_q[DATA_W-2:0], 1'b0};
              cnt_n = cnt_q + 1'b1;
            end
          end
        end

        default: sdo_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      opc_q  <= OP_EXT;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
      we_q   <= 1'b0;
      stat_q <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      opc_q  <= opc_n;
      addr_q <= addr_n;
      data_q <= data_n;
      rd_q   <= rd_n;
      we_q   <= we_n;
      stat_q <= stat_n;
      sdo_q  <= sdo_n;
    end
  end

  assign sdo = sdo_q;

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> (st_q == ST_IDLE));

  // R8
  wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_one || wr_all) |-> we_q);

  // R2
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READ && cs_s && !rise) |=> $stable(sdo_q));

  // R6
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_one, wr_all}));

endmodule

// File: rtl/mw_eeprom_model.sv
module mw_eeprom_model #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  output logic sdo
);

  logic              cs_s, sdi_s, rise, busy, launch;
  logic              wr_one, wr_all;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_word, wr_data;

  mw_edge_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_pin   (cs),
    .sclk_pin (sclk),
    .sdi_pin  (sdi),
    .cs_s     (cs_s),
    .sdi_s    (sdi_s),
    .rise     (rise)
  );

  mw_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .sdi_s   (sdi_s),
    .rise    (rise),
    .busy    (busy),
    .rd_word (rd_word),
    .rd_addr (rd_addr),
    .wr_one  (wr_one),
    .wr_all  (wr_all),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .launch  (launch),
    .sdo     (sdo)
  );

  mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_one  (wr_one),
    .wr_all  (wr_all),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_word)
  );

  mw_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .busy   (busy)
  );

endmodule

// File: tb/sim_mw_eeprom_model.sv
`timescale 1ns/1ps
module sim_mw_eeprom_model;

  localparam int AW    = 6;
  localparam int BUSY  = 40;
  localparam int H     = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mw_eeprom_model #(.ADDR_W(AW), .DATA_W(16), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi), .sdo(sdo)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 2531) ^ 16'hA5C3 ^ (a << 9));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic o);
    sclk = 1'b0;
    sdi  = b;
    repeat (H) @(negedge clk);
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    o = sdo;
  endtask

  task automatic cs_on();
    cs = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_off();
    sclk = 1'b0;
    sdi  = 1'b0;
    repeat (H) @(negedge clk);
    cs = 1'b0;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic head(input logic [1:0] op, input logic [AW-1:0] a, output logic o);
    sbit(1'b1, o);
    sbit(op[1], o);
    sbit(op[0], o);
    for (int i = AW - 1; i >= 0; i--) sbit(a[i], o);
  endtask

  task automatic read_word(input int a, output logic [15:0] v, output logic dummy);
    logic o;
    cs_on();
    head(2'b10, AW'(a), dummy);
    v = '0;
    for (int i = 0; i < 16; i++) begin
      sbit(1'b0, o);
      v = {v[14:0], o};
    end
    cs_off();
  endtask

  task automatic send_data(input logic [15:0] d);
    logic o;
    for (int i = 15; i >= 0; i--) sbit(d[i], o);
  endtask

  task automatic write_word(input int a, input logic [15:0] d);
    logic o;
    cs_on();
    head(2'b01, AW'(a), o);
    send_data(d);
    cs_off();
  endtask

  task automatic erase_word(input int a);
    logic o;
    cs_on();
    head(2'b11, AW'(a), o);
    cs_off();
  endtask

  task automatic ext_cmd(input logic [1:0] fn, input logic [AW-3:0] low);
    logic o;
    cs_on();
    head(2'b00, {fn, low}, o);
    cs_off();
  endtask

  task automatic fill_all(input logic [15:0] d);
    logic o;
    cs_on();
    head(2'b00, {2'b01, {(AW-2){1'b0}}}, o);
    send_data(d);
    cs_off();
  endtask

  // select again, check busy at first, then wait for ready
  task automatic poll_ready(input string req);
    int n;
    cs_on();
    chk(req, int'(sdo), 0);
    n = 0;
    while (sdo !== 1'b1 && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(req, int'(sdo), 1);
    cs_off();
  endtask

  task automatic no_status(input string req);
    cs_on();
    repeat (BUSY + 20) @(negedge clk);
    chk(req, int'(sdo), 0);
    cs_off();
  endtask

  task automatic sweep(input string req, input int mode, input logic [15:0] k);
    logic [15:0] v;
    logic d;
    for (int a = 0; a < DEPTH; a++) begin
      read_word(a, v, d);
      chk("R2 dummy", int'(d), 0);
      chk(req, int'(v), (mode == 0) ? int'(pat(a)) : int'(k));
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(negedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] v;
    logic d, o;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: output low, array erased
    chk("R1 sdo", int'(sdo), 0);
    read_word(0, v, d);
    chk("R1 word0", int'(v), 16'hFFFF);
    read_word(DEPTH - 1, v, d);
    chk("R1 wordlast", int'(v), 16'hFFFF);

    // R8: latch clear after reset
    write_word(5, 16'h1234);
    no_status("R8 no busy");
    read_word(5, v, d);
    chk("R8 locked write", int'(v), 16'hFFFF);

    // R5: unlock, low bits don't care
    ext_cmd(2'b11, 4'b1010);

    // R3 + R9: sweep of all addresses
    for (int a = 0; a < DEPTH; a++) begin
      write_word(a, pat(a));
      poll_ready("R9 status");
    end
    sweep("R3 write sweep", 0, 16'h0);

    // R4: single erase, neighbour intact
    erase_word(10);
    poll_ready("R9 erase status");
    read_word(10, v, d);
    chk("R4 erased", int'(v), 16'hFFFF);
    read_word(11, v, d);
    chk("R4 neighbour", int'(v), int'(pat(11)));

    // R10: write cut short by select
    cs_on();
    head(2'b01, AW'(20), o);
    for (int i = 0; i < 8; i++) sbit(1'b0, o);
    cs_off();
    read_word(20, v, d);
    chk("R10 aborted", int'(v), int'(pat(20)));
    write_word(22, 16'h0F0F);
    poll_ready("R10 next cmd");
    read_word(22, v, d);
    chk("R10 next cmd", int'(v), 16'h0F0F);

    // R11: start bit while busy is ignored
    write_word(21, 16'hBEEF);
    cs_on();
    sbit(1'b1, o);
    chk("R11 busy", int'(sdo), 0);
    sclk = 1'b0;
    repeat (BUSY + 20) @(negedge clk);
    chk("R11 ready", int'(sdo), 1);
    cs_off();
    read_word(21, v, d);
    chk("R11 stored", int'(v), 16'hBEEF);

    // R7: fill every word
    fill_all(16'h3C5A);
    poll_ready("R9 fill status");
    sweep("R7 fill sweep", 1, 16'h3C5A);

    // R6: clear every word
    ext_cmd(2'b10, 4'b0110);
    poll_ready("R9 clear status");
    sweep("R6 clear sweep", 1, 16'hFFFF);

    // R5 + R8: lock again, then programming is ignored
    ext_cmd(2'b00, 4'b1111);
    write_word(3, 16'h0000);
    no_status("R8 no busy locked");
    read_word(3, v, d);
    chk("R8 write locked", int'(v), 16'hFFFF);
    fill_all(16'h0000);
    read_word(0, v, d);
    chk("R8 fill locked", int'(v), 16'hFFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule